// File: doc/BRIEF.md
# Prefix-Driven Add-With-Carry Execute Stage

This block is the integer-add slice of a small 16-bit graphics coprocessor's execute stage. It takes decoded opcode bytes one at a time over a valid/ready handshake. It keeps a sixteen-entry register file, four arithmetic flags and a small amount of prefix state. Prefix bytes do not compute anything. They choose which register is read as the first addend, which register receives the sum, whether the low nibble of the add byte names a register or is a literal, and whether the stored carry joins the sum.

When an add byte arrives, the unit captures the sum at once and holds off further bytes for a fixed latency. That latency is one of two parameters, picked by a per-byte input that tells whether the byte came from the instruction cache or from slower memory. At the end of the latency the unit writes the sum and the flags, pulses `done`, and returns every prefix choice to its default: register 0 for both roles and no mode bits. A byte the unit does not recognise is taken in a single cycle and also returns the prefix state to its defaults.

An observation read port lets the surrounding logic, or a bench, read any register without disturbing execution.

Top module: `adc_exec_unit`

## Requirements
- R1: After a synchronous active-high reset, all sixteen registers read 0, `flags_o` is 0, `done` is low and `in_ready` is high.
- R2: Mode prefixes are set-only bits. 3Dh sets mode bit A, 3Eh sets mode bit B and 3Fh sets both. An add byte 5nh computes with carry-in only when bit A is set, and it takes nibble n as a literal only when bit B is set. With neither bit set, 5nh is a plain register add that ignores the stored carry.
- R3: The sum, first addend + second addend + carry-in, is written to the destination register and appears on `wr_data`, with the destination index on `wr_idx`, while `done` is high.
- R4: In the literal form, the second addend is n zero-extended to 16 bits.
- R5: If no prefix has chosen them, the first-addend register and the destination register are both register 0.
- R6: Byte 2nh chooses register n for both the source and the destination. Byte Bnh chooses only the source, and byte 1nh chooses only the destination.
- R7: When an add completes, and when any byte outside the prefix and add groups is taken, the mode bits and register choices return to their defaults.
- R8: `flags_o` = {overflow, sign, carry, zero}, bit 3 down to bit 0. Carry is bit 16 of the 17-bit sum. Overflow is set when both addends have the same sign and the result's sign differs. Sign is result bit 15. Zero is set when the 16-bit result is 0.
- R9: Taking a prefix byte leaves `flags_o` unchanged.
- R10: `in_ready` is low from the cycle after an add byte is accepted until `done`. `done` is a one-cycle pulse exactly LAT_CACHE cycles after acceptance when `from_cache` was high at acceptance, and LAT_MEM cycles after otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Opcode byte is valid |
| in_byte | input | 8 | Opcode byte |
| from_cache | input | 1 | Byte came from the instruction cache (short latency) |
| in_ready | output | 1 | Unit can take a byte this cycle |
| done | output | 1 | One-cycle pulse when an add commits |
| wr_idx | output | 4 | Destination index of the committed add |
| wr_data | output | 16 | Committed sum |
| flags_o | output | 4 | {overflow, sign, carry, zero} |
| obs_idx | input | 4 | Observation read index |
| obs_data | output | 16 | Register contents at obs_idx |

## Verification
The bench builds the unit with a two-cycle cache latency and a six-cycle memory latency, and it switches `from_cache` between add bytes. This puts both latency paths, and the ready back-pressure in between, on every stretch of the run. A doubling sequence and a "twice plus one" sequence build 4000h, 8000h and FFFFh. These values reach signed overflow from both signs, a carry-out to zero, and carry-in consumed by the following add. Both register-form and literal-form operation sequences with chained prefixes are replayed against an independent integer model.

// File: rtl/fxa_pkg.sv
package fxa_pkg;
  localparam int DW = 16;

  typedef struct packed {
    logic ov;
    logic sgn;
    logic cy;
    logic zr;
  } fxa_flags_t;

  typedef struct packed {
    logic [DW-1:0] sum;
    fxa_flags_t    fl;
  } fxa_res_t;

  typedef enum logic [2:0] {
    OP_TO, OP_WITH, OP_FROM, OP_ALT, OP_ARITH, OP_OTHER
  } fxa_op_e;

  // Add two operands plus carry-in and derive the four flags from the sum.
  function automatic fxa_res_t fxa_add(input logic [DW-1:0] a,
                                       input logic [DW-1:0] b,
                                       input logic cin);
    logic [DW:0] w;
    fxa_res_t    r;
    w        = {1'b0, a} + {1'b0, b} + (DW+1)'(cin);
    r.sum    = w[DW-1:0];
    r.fl.cy  = w[DW];
    r.fl.sgn = w[DW-1];
    r.fl.ov  = (a[DW-1] == b[DW-1]) && (w[DW-1] != a[DW-1]);
    r.fl.zr  = (w[DW-1:0] == '0);
    return r;
  endfunction

  // Sort an opcode byte into one of the groups the unit handles.
  function automatic fxa_op_e fxa_classify(input logic [7:0] b);
    case (b[7:4])
      4'h1:    return OP_TO;
      4'h2:    return OP_WITH;
      4'hB:    return OP_FROM;
      4'h3:    return (b[3:0] >= 4'hD) ? OP_ALT : OP_OTHER;
      4'h5:    return OP_ARITH;
      default: return OP_OTHER;
    endcase
  endfunction
endpackage

// File: rtl/fxa_prefix.sv
module fxa_prefix
  import fxa_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [7:0]       byte_i,
  input  logic             clr,
  output logic             alt_a,
  output logic             alt_b,
  output logic [IDX_W-1:0] src,
  output logic [IDX_W-1:0] dst
);
  logic    bsel;
  fxa_op_e cls;
  assign cls = fxa_classify(byte_i);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      alt_a <= 1'b0;
      alt_b <= 1'b0;
      bsel  <= 1'b0;
      src   <= '0;
      dst   <= '0;
    end else if (load) begin
      case (cls)
        OP_ALT: begin
          alt_a <= alt_a | byte_i[0];
          alt_b <= alt_b | byte_i[1];
        end
        OP_WITH: begin
          src  <= IDX_W'(byte_i[3:0]);
          dst  <= IDX_W'(byte_i[3:0]);
          bsel <= 1'b1;
        end
        OP_FROM: src <= IDX_W'(byte_i[3:0]);
        OP_TO:   dst <= IDX_W'(byte_i[3:0]);
        default: ;
      endcase
    end
  end

  // R7
  prefix_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!alt_a && !alt_b && !bsel && src == '0 && dst == '0));

  // R6
  with_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !clr && cls == OP_WITH) |=> (src == dst && bsel));
endmodule

// File: rtl/fxa_regfile.sv
module fxa_regfile #(
  parameter int IDX_W = 4,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] wa,
  input  logic [DW-1:0]    wd,
  input  logic [IDX_W-1:0] ra,
  input  logic [IDX_W-1:0] rb,
  input  logic [IDX_W-1:0] rc,
  output logic [DW-1:0]    qa,
  output logic [DW-1:0]    qb,
  output logic [DW-1:0]    qc
);
  localparam int NREG = 1 << IDX_W;

  logic [NREG-1:0][DW-1:0] flat;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                           q <= '0;
      else if (we && wa == IDX_W'(g))    q <= wd;
    end
    assign flat[g] = q;
  end

  assign qa = flat[ra];
  assign qb = flat[rb];
  assign qc = flat[rc];
endmodule

// File: rtl/fxa_timer.sv
module fxa_timer #(
  parameter int LAT_CACHE = 2,
  parameter int LAT_MEM   = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic from_cache,
  output logic busy,
  output logic fire
);
  localparam int LMAX  = (LAT_CACHE > LAT_MEM) ? LAT_CACHE : LAT_MEM;
  localparam int CNT_W = $clog2(LMAX + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= from_cache ? CNT_W'(LAT_CACHE - 1) : CNT_W'(LAT_MEM - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign fire = busy && (cnt == '0);
endmodule

// File: rtl/adc_exec_unit.sv
module adc_exec_unit
  import fxa_pkg::*;
#(
  parameter int LAT_CACHE = 2,
  parameter int LAT_MEM   = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  input  logic        from_cache,
  output logic        in_ready,
  output logic        done,
  output logic [3:0]  wr_idx,
  output logic [15:0] wr_data,
  output logic [3:0]  flags_o,
  input  logic [3:0]  obs_idx,
  output logic [15:0] obs_data
);
  localparam int IDX_W = 4;

  fxa_op_e    cls;
  logic       acc, pre_ld, arith_go, other_go, busy, fire;
  logic       alt_a, alt_b;
  logic [IDX_W-1:0] src, dst, pend_dst;
  logic [DW-1:0] rd_src, rd_opnd, opnd_b;
  fxa_res_t   res, pend;
  fxa_flags_t flags;
  logic       done_q;

  assign cls      = fxa_classify(in_byte);
  assign acc      = in_valid && in_ready;
  assign pre_ld   = acc && (cls == OP_ALT || cls == OP_WITH ||
                            cls == OP_FROM || cls == OP_TO);
  assign arith_go = acc && (cls == OP_ARITH);
  assign other_go = acc && (cls == OP_OTHER);
  assign in_ready = !busy;

  fxa_prefix #(.IDX_W(IDX_W)) u_prefix (
    .clk(clk), .rst(rst), .load(pre_ld), .byte_i(in_byte),
    .clr(fire || other_go),
    .alt_a(alt_a), .alt_b(alt_b), .src(src), .dst(dst)
  );

  fxa_regfile #(.IDX_W(IDX_W), .DW(DW)) u_rf (
    .clk(clk), .rst(rst),
    .we(fire), .wa(pend_dst), .wd(pend.sum),
    .ra(src), .rb(IDX_W'(in_byte[3:0])), .rc(obs_idx),
    .qa(rd_src), .qb(rd_opnd), .qc(obs_data)
  );

  fxa_timer #(.LAT_CACHE(LAT_CACHE), .LAT_MEM(LAT_MEM)) u_timer (
    .clk(clk), .rst(rst), .start(arith_go), .from_cache(from_cache),
    .busy(busy), .fire(fire)
  );

  // Mode bit B picks the literal form, mode bit A admits the stored carry.
  assign opnd_b = alt_b ? DW'(in_byte[3:0]) : rd_opnd;
  assign res    = fxa_add(rd_src, opnd_b, alt_a & flags.cy);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags    <= '0;
      pend     <= '0;
      pend_dst <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= fire;
      if (arith_go) begin
        pend     <= res;
        pend_dst <= dst;
      end
      if (fire) flags <= pend.fl;
    end
  end

  assign done    = done_q;
  assign wr_idx  = pend_dst;
  assign wr_data = pend.sum;
  assign flags_o = flags;

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    arith_go |=> !in_ready);

  // R9
  prefix_flags_chk: assert property (@(posedge clk) disable iff (rst)
    pre_ld |=> $stable(flags_o));

  // R8
  zero_match_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (flags_o[0] == (wr_data == '0)));

  // R8
  sign_match_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (flags_o[2] == wr_data[15]));
endmodule

// File: tb/adc_exec_unit_tb_top.sv
module adc_exec_unit_tb_top;
  localparam int LC = 2;
  localparam int LM = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        from_cache = 1'b0;
  logic        in_ready, done;
  logic [3:0]  wr_idx, flags_o;
  logic [15:0] wr_data, obs_data;
  logic [3:0]  obs_idx = 4'd0;

  always #5 clk = ~clk;

  adc_exec_unit #(.LAT_CACHE(LC), .LAT_MEM(LM)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .from_cache(from_cache), .in_ready(in_ready), .done(done),
    .wr_idx(wr_idx), .wr_data(wr_data), .flags_o(flags_o),
    .obs_idx(obs_idx), .obs_data(obs_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [31:0] cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct packed {
    logic [3:0]  idx;
    logic [15:0] data;
    logic [3:0]  fl;
    logic [3:0]  lat;
    logic [31:0] acc;
  } exp_t;
  exp_t q[$];

  // Reference model state
  logic [15:0] mr [16];
  logic [3:0]  mfl;
  logic        ma, mb;
  logic [3:0]  ms, md;

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic mclear();
    ma = 0; mb = 0; ms = 0; md = 0;
  endtask

  // Driver: hand one byte over, update the model, queue expectations.
  task automatic send(input logic [7:0] b, input logic cache);
    exp_t e;
    int a, o, cin, s, sa, so, ss;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_byte = b; from_cache = cache;
    @(posedge clk);
    #1;
    in_valid = 0;
    case (b[7:4])
      4'h1: md = b[3:0];
      4'h2: begin ms = b[3:0]; md = b[3:0]; end
      4'hB: ms = b[3:0];
      4'h3: begin
        if (b[3:0] == 4'hD)      ma = 1;
        else if (b[3:0] == 4'hE) mb = 1;
        else if (b[3:0] == 4'hF) begin ma = 1; mb = 1; end
        else mclear();
      end
      4'h5: begin
        a   = int'(mr[ms]);
        o   = mb ? int'(b[3:0]) : int'(mr[b[3:0]]);   // R4 literal / register
        cin = ma ? int'(mfl[1]) : 0;                   // R2 carry only in mode A
        s   = a + o + cin;
        sa  = (a >= 32768) ? a - 65536 : a;
        so  = (o >= 32768) ? o - 65536 : o;
        ss  = sa + so + cin;
        e.idx  = md;
        e.data = s[15:0];
        e.fl   = {(ss > 32767 || ss < -32768), s[15], (s > 65535), (s[15:0] == 0)};
        e.lat  = cache ? 4'(LC) : 4'(LM);
        e.acc  = cyc;
        q.push_back(e);
        mr[md] = s[15:0];
        mfl    = e.fl;
        mclear();
      end
      default: mclear();
    endcase
    @(negedge clk);
    if (b[7:4] == 4'h5)
      chk(in_ready == 0, "R10 ready low while busy", 32'(in_ready), 0);
    else if (b[7:4] == 4'h1 || b[7:4] == 4'h2 || b[7:4] == 4'hB ||
             (b[7:4] == 4'h3 && b[3:0] >= 4'hD))
      chk(flags_o == mfl, "R9 prefix keeps flags", 32'(flags_o), 32'(mfl));
  endtask

  // Monitor: compare each commit against the queue head.
  always @(negedge clk) begin
    if (!rst && done) begin
      if (q.size() == 0) begin
        chk(0, "R10 done without pending add", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(wr_idx == e.idx, "R3 R5 R6 destination index", 32'(wr_idx), 32'(e.idx));
        chk(wr_data == e.data, "R3 sum value", 32'(wr_data), 32'(e.data));
        chk(flags_o == e.fl, "R8 flags", 32'(flags_o), 32'(e.fl));
        chk((cyc - e.acc) == 32'(e.lat), "R10 latency", cyc - e.acc, 32'(e.lat));
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit c;
    bit allz;
    for (int i = 0; i < 16; i++) mr[i] = 16'h0;
    mfl = 0;
    mclear();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1, "R1 ready after reset", 32'(in_ready), 1);
    chk(done == 0, "R1 done after reset", 32'(done), 0);
    chk(flags_o == 0, "R1 flags after reset", 32'(flags_o), 0);
    allz = 1;
    for (int i = 0; i < 16; i++) begin
      obs_idx = 4'(i); #1;
      if (obs_data != 0) allz = 0;
    end
    chk(allz, "R1 registers zero", 32'(allz), 1);

    // R5 default R0, literal form
    send(8'h3E, 1); send(8'h55, 1);
    // R6 TO and FROM
    send(8'h11, 0); send(8'hB1, 0); send(8'h3E, 0); send(8'h51, 0);
    send(8'h12, 1); send(8'h3E, 1); send(8'h5F, 1);
    send(8'h13, 0); send(8'h3E, 0); send(8'h57, 0);
    // Doubling R1 up to 4000h, alternating latency source
    c = 0;
    for (int i = 0; i < 14; i++) begin
      send(8'h21, c); send(8'h51, c); c = ~c;
    end
    // R8 positive overflow to 8000h
    send(8'h1A, 0); send(8'hB1, 0); send(8'h51, 0);
    send(8'h14, 1); send(8'hB1, 1); send(8'h51, 1);
    // R8 carry-out to zero
    send(8'h24, 0); send(8'h54, 0);
    // First operation sequence, register form with carry (R2)
    send(8'h3D, 1); send(8'h51, 1);
    send(8'h22, 0); send(8'h3D, 0); send(8'h53, 0);
    send(8'h3D, 1); send(8'h52, 1);
    // Second operation sequence, literal form with carry
    send(8'h3F, 0); send(8'h59, 0);
    send(8'hB3, 1); send(8'h3F, 1); send(8'h55, 1);
    send(8'h3F, 0); send(8'h5A, 0);
    // Build FFFFh in R5 by twice-plus-one
    for (int i = 0; i < 16; i++) begin
      send(8'h25, c); send(8'h55, c);
      send(8'h25, c); send(8'h3E, c); send(8'h51, c); c = ~c;
    end
    // FFFFh + 1 sets carry, then a plain add must ignore it (R2)
    send(8'h16, 0); send(8'hB5, 0); send(8'h3E, 0); send(8'h51, 0);
    send(8'h17, 1); send(8'h53, 1);
    send(8'h16, 0); send(8'hB5, 0); send(8'h3E, 0); send(8'h51, 0);
    send(8'h3E, 1); send(8'h53, 1);
    // R8 negative overflow: 8000h + FFFFh
    send(8'h2A, 0); send(8'h55, 0);
    // R7 unknown byte clears prefixes
    send(8'h29, 1); send(8'h4C, 1); send(8'h3E, 1); send(8'h51, 1);
    send(8'h16, 0); send(8'hB5, 0); send(8'h3E, 0); send(8'h51, 0);
    send(8'h3D, 0); send(8'h00, 0); send(8'h51, 0);
    // Drain, then read every register back (R3)
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      obs_idx = 4'(i); #1;
      chk(obs_data == mr[i], "R3 register readback", 32'(obs_data), 32'(mr[i]));
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule